// File: doc/BRIEF.md
# Tick Counter with Compare Interrupt

This block is a per-processor cycle timer. It holds a 64-bit register whose low 63 bits count one step per clock and whose top bit is a read-permission flag. Next to it sit one or more 64-bit compare registers. Each compare register raises its own bit in a soft-interrupt status word when the count reaches the programmed value. The top bit of each compare register is a disable flag rather than part of the match value.

Software uses a single access port, one operation per cycle. It can read the counter, overwrite it, adjust it by an offset, write a compare register and read a compare register back. Read results return one cycle after the request. An unprivileged read of the counter is refused while the permission flag is set. Status bits stay set until software clears them with a masked strobe.

Top module: `tick_timer`

## Requirements
- R1: After reset the counter's top bit (permission flag) is 1 and its low 63 bits start from 0. Every compare register reads 0x8000_0000_0000_0000, i.e. disabled. `softint`, `rd_valid`, `rd_data` and `priv_fault` are all 0.
- R2: In a cycle with no write or adjust, the low 63 bits of the counter advance by one and wrap from all ones to zero. The top bit is unchanged.
- R3: A write-count operation (`acc_op` = 2) loads all 64 bits of `acc_wdata`, including the permission flag, at the next clock edge.
- R4: An adjust operation (`acc_op` = 3) sets the low 63 bits to old + 1 + `acc_wdata[62:0]`, modulo 2^63, and keeps the permission flag.
- R5: A read-count operation (`acc_op` = 1) with `acc_priv` = 1 returns all 64 bits of the counter as held in the request cycle. The result is on `rd_data` with `rd_valid` = 1 in the following cycle.
- R6: A read-count with `acc_priv` = 0 while the flag is 1 returns 0 and raises `priv_fault` for exactly that result cycle. With the flag at 0 it returns the value and no fault.
- R7: A compare write (`acc_op` = 4, channel `acc_sel`) stores all 64 bits. A compare read (`acc_op` = 5) returns exactly the last value written to that channel, regardless of privilege.
- R8: When a compare register's bit 63 is 0 and its low 63 bits equal the counter's low 63 bits, the channel's status bit is set one cycle later. Channel i owns `softint` bit 16*i, so channel 0 uses bit 0 and channel 1 uses bit 16.
- R9: A compare register with bit 63 set never sets its status bit.
- R10: A compare value that the counter has already passed raises no interrupt until the count reaches it again.
- R11: A status bit stays set until a cycle with `softint_clr` = 1 and the corresponding bit of `softint_clr_mask` set. Bits outside the mask are untouched.
- R12: If a match and a clear of the same bit fall in the same cycle, the bit is set afterwards.
- R13: In a cycle after a non-read request or no request, `rd_valid`, `rd_data` and `priv_fault` are 0. Op codes 0, 6 and 7 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Access request this cycle |
| acc_op | input | 3 | Operation code (see requirements) |
| acc_sel | input | SEL_W | Compare channel for compare operations |
| acc_priv | input | 1 | Requester is privileged |
| acc_wdata | input | CNT_W | Write value or adjust offset |
| softint_clr | input | 1 | Clear strobe for status bits |
| softint_clr_mask | input | SOFT_W | Bits cleared by the strobe |
| rd_valid | output | 1 | Read result present |
| rd_data | output | CNT_W | Read result |
| priv_fault | output | 1 | Refused unprivileged counter read |
| softint | output | SOFT_W | Soft-interrupt status bits |

## Verification
The bench targets the off-by-one points of the match path. A design that compared against the next count instead of the current one would set the status bit a cycle early. A design that used greater-or-equal would fire at once on a compare value already behind the counter. A clear landing on the match cycle has to leave the bit set; a design that let the clear win would lose the interrupt. The bench also wraps the low count past all ones with the flag both set and clear, to catch a carry leaking into the flag. It reads the counter unprivileged on both sides of the flag, to catch a design that leaks the count or faults on a permitted read.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_RD_CNT  = 3'd1,
        OP_WR_CNT  = 3'd2,
        OP_ADJ_CNT = 3'd3,
        OP_WR_CMP  = 3'd4,
        OP_RD_CMP  = 3'd5
    } tick_op_e;

    localparam int SOFT_STRIDE = 16;

    typedef struct packed {
        logic rd_cnt;
        logic wr_cnt;
        logic adj_cnt;
        logic wr_cmp;
        logic rd_cmp;
    } tick_cmd_t;

    function automatic tick_cmd_t decode_cmd(input logic valid, input logic [2:0] op);
        tick_cmd_t c;
        c = '0;
        if (valid) begin
            case (op)
                3'd1:    c.rd_cnt  = 1'b1;
                3'd2:    c.wr_cnt  = 1'b1;
                3'd3:    c.adj_cnt = 1'b1;
                3'd4:    c.wr_cmp  = 1'b1;
                3'd5:    c.rd_cmp  = 1'b1;
                default: c = '0;
            endcase
        end
        return c;
    endfunction

    function automatic int soft_pos(input int idx);
        return idx * SOFT_STRIDE;
    endfunction

endpackage

// File: rtl/tick_counter.sv
module tick_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic         adj_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cnt_q
);
    localparam int LW = W - 1;
    localparam logic [LW-1:0] STEP = LW'(1);

    logic [LW-1:0] low_next;

    always_comb begin
        low_next = cnt_q[LW-1:0] + STEP;
        if (adj_en)
            low_next = cnt_q[LW-1:0] + STEP + wdata[LW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= {1'b1, {LW{1'b0}}};
        else if (wr_en)
            cnt_q <= wdata;
        else
            cnt_q <= {cnt_q[W-1], low_next};
    end
endmodule

// File: rtl/tick_compare.sv
module tick_compare #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt_q,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    localparam int LW = W - 1;

    always_ff @(posedge clk) begin
        if (rst)
            cmp_q <= {1'b1, {LW{1'b0}}};
        else if (wr_en)
            cmp_q <= wdata;
    end

    assign hit = !cmp_q[W-1] && (cmp_q[LW-1:0] == cnt_q[LW-1:0]);
endmodule

// File: rtl/tick_softint.sv
module tick_softint #(
    parameter int SOFT_W  = 17,
    parameter int NUM_CMP = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_CMP-1:0] hit,
    input  logic               clr,
    input  logic [SOFT_W-1:0]  clr_mask,
    output logic [SOFT_W-1:0]  softint
);
    import tick_pkg::*;

    logic [SOFT_W-1:0] set_vec;
    logic [SOFT_W-1:0] kept;

    always_comb begin
        set_vec = '0;
        for (int i = 0; i < NUM_CMP; i++)
            set_vec[soft_pos(i)] = hit[i];
    end

    assign kept = clr ? (softint & ~clr_mask) : softint;

    always_ff @(posedge clk) begin
        if (rst)
            softint <= '0;
        else
            softint <= kept | set_vec;
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W   = 64,
    parameter int NUM_CMP = 2,
    parameter int SOFT_W  = 17,
    parameter int SEL_W   = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [2:0]        acc_op,
    input  logic [SEL_W-1:0]  acc_sel,
    input  logic              acc_priv,
    input  logic [CNT_W-1:0]  acc_wdata,
    input  logic              softint_clr,
    input  logic [SOFT_W-1:0] softint_clr_mask,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data,
    output logic              priv_fault,
    output logic [SOFT_W-1:0] softint
);
    import tick_pkg::*;

    localparam int MSB = CNT_W - 1;

    tick_cmd_t                       cmd;
    logic [CNT_W-1:0]                cnt_q;
    logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val;
    logic [NUM_CMP-1:0]              hit;
    logic                            blocked;

    assign cmd     = decode_cmd(acc_valid, acc_op);
    assign blocked = cmd.rd_cnt && !acc_priv && cnt_q[MSB];

    tick_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (cmd.wr_cnt),
        .adj_en (cmd.adj_cnt),
        .wdata  (acc_wdata),
        .cnt_q  (cnt_q)
    );

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
        tick_compare #(.W(CNT_W)) u_cmp (
            .clk   (clk),
            .rst   (rst),
            .wr_en (cmd.wr_cmp && (acc_sel == SEL_W'(g))),
            .wdata (acc_wdata),
            .cnt_q (cnt_q),
            .cmp_q (cmp_val[g]),
            .hit   (hit[g])
        );
    end

    tick_softint #(.SOFT_W(SOFT_W), .NUM_CMP(NUM_CMP)) u_soft (
        .clk      (clk),
        .rst      (rst),
        .hit      (hit),
        .clr      (softint_clr),
        .clr_mask (softint_clr_mask),
        .softint  (softint)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid   <= 1'b0;
            rd_data    <= '0;
            priv_fault <= 1'b0;
        end else begin
            rd_valid   <= cmd.rd_cnt || cmd.rd_cmp;
            priv_fault <= blocked;
            if (cmd.rd_cnt)
                rd_data <= blocked ? '0 : cnt_q;
            else if (cmd.rd_cmp)
                rd_data <= cmp_val[acc_sel];
            else
                rd_data <= '0;
        end
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W   = 64,
    parameter int NUM_CMP = 2,
    parameter int SOFT_W  = 17,
    parameter int SEL_W   = 1
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            acc_valid,
    input logic [2:0]                      acc_op,
    input logic [SEL_W-1:0]                acc_sel,
    input logic                            softint_clr,
    input logic [SOFT_W-1:0]               softint_clr_mask,
    input logic [CNT_W-1:0]                acc_wdata,
    input logic                            rd_valid,
    input logic [CNT_W-1:0]                rd_data,
    input logic                            priv_fault,
    input logic [SOFT_W-1:0]               softint,
    input logic [CNT_W-1:0]                cnt_q,
    input logic [NUM_CMP-1:0][CNT_W-1:0]   cmp_val,
    input logic [NUM_CMP-1:0]              hit
);
    localparam int LW = CNT_W - 1;
    localparam logic [LW-1:0] ONE = LW'(1);

    logic cnt_loaded;
    assign cnt_loaded = acc_valid && (acc_op == 3'd2 || acc_op == 3'd3);

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        !cnt_loaded |=> (cnt_q[LW-1:0] == $past(cnt_q[LW-1:0]) + ONE)
                        && (cnt_q[CNT_W-1] == $past(cnt_q[CNT_W-1])));

    assert_fault_zero_R6: assert property (@(posedge clk) disable iff (rst)
        priv_fault |-> (rd_valid && rd_data == '0));

    assert_cmp_load_R7: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_op == 3'd4) |=> cmp_val[$past(acc_sel)] == $past(acc_wdata));

    assert_rd_idle_R13: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> (!rd_valid && !priv_fault && rd_data == '0));

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_chan
        localparam int P = g * 16;

        assert_disable_quiet_R9: assert property (@(posedge clk) disable iff (rst)
            (cmp_val[g][CNT_W-1] && !softint[P]) |=> !softint[P]);

        assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
            (softint[P] && !(softint_clr && softint_clr_mask[P])) |=> softint[P]);

        assert_match_wins_R12: assert property (@(posedge clk) disable iff (rst)
            hit[g] |=> softint[P]);
    end
endmodule

bind tick_timer tick_timer_chk #(
    .CNT_W(CNT_W), .NUM_CMP(NUM_CMP), .SOFT_W(SOFT_W), .SEL_W(SEL_W)
) u_chk (
    .clk              (clk),
    .rst              (rst),
    .acc_valid        (acc_valid),
    .acc_op           (acc_op),
    .acc_sel          (acc_sel),
    .softint_clr      (softint_clr),
    .softint_clr_mask (softint_clr_mask),
    .acc_wdata        (acc_wdata),
    .rd_valid         (rd_valid),
    .rd_data          (rd_data),
    .priv_fault       (priv_fault),
    .softint          (softint),
    .cnt_q            (cnt_q),
    .cmp_val          (cmp_val),
    .hit              (hit)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_op = 3'd0;
    logic [0:0]  acc_sel = 1'b0;
    logic        acc_priv = 1'b1;
    logic [63:0] acc_wdata = '0;
    logic        softint_clr = 1'b0;
    logic [16:0] softint_clr_mask = '0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic        priv_fault;
    logic [16:0] softint;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tick_timer u_dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_op(acc_op),
        .acc_sel(acc_sel), .acc_priv(acc_priv), .acc_wdata(acc_wdata),
        .softint_clr(softint_clr), .softint_clr_mask(softint_clr_mask),
        .rd_valid(rd_valid), .rd_data(rd_data), .priv_fault(priv_fault),
        .softint(softint)
    );

    // behavioural reference
    logic [63:0] m_cnt;
    logic [63:0] m_cmp [2];
    logic [16:0] m_soft;
    logic [63:0] m_rd;
    logic        m_rdv, m_flt;

    localparam logic [63:0] LOW_MASK = 64'h7FFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] TOP      = 64'h8000_0000_0000_0000;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = TOP; m_cmp[0] = TOP; m_cmp[1] = TOP;
            m_soft = '0; m_rd = '0; m_rdv = 0; m_flt = 0;
        end else begin
            logic [16:0] s;
            logic [63:0] nc;
            s = softint_clr ? (m_soft & ~softint_clr_mask) : m_soft;
            for (int k = 0; k < 2; k++)
                if (!m_cmp[k][63] && ((m_cmp[k] & LOW_MASK) == (m_cnt & LOW_MASK)))
                    s[k*16] = 1'b1;
            m_rdv = 0; m_flt = 0; m_rd = '0;
            nc = (m_cnt & TOP) | ((m_cnt + 64'd1) & LOW_MASK);
            if (acc_valid) begin
                if (acc_op == 3'd1) begin
                    m_rdv = 1;
                    if (!acc_priv && m_cnt[63]) m_flt = 1;
                    else m_rd = m_cnt;
                end else if (acc_op == 3'd5) begin
                    m_rdv = 1; m_rd = m_cmp[acc_sel];
                end else if (acc_op == 3'd2) begin
                    nc = acc_wdata;
                end else if (acc_op == 3'd3) begin
                    nc = (m_cnt & TOP) | ((m_cnt + 64'd1 + acc_wdata) & LOW_MASK);
                end else if (acc_op == 3'd4) begin
                    m_cmp[acc_sel] = acc_wdata;
                end
            end
            m_cnt = nc;
            m_soft = s;
        end
    end

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R8 R11 model softint", {47'd0, softint}, {47'd0, m_soft});
            check("R13 model rd_valid", {63'd0, rd_valid}, {63'd0, m_rdv});
            check("R5 R7 model rd_data", rd_data, m_rd);
            check("R6 model priv_fault", {63'd0, priv_fault}, {63'd0, m_flt});
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000 && !done) begin
            tests++; fails++;
            $display("FAIL R13 watchdog actual=%0d expected=<20000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic op(input logic [2:0] o, input logic s, input logic p, input logic [63:0] d);
        acc_valid = 1; acc_op = o; acc_sel = s; acc_priv = p; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_op = 3'd0; acc_priv = 1; acc_wdata = '0;
    endtask

    task automatic clr(input logic [16:0] m);
        softint_clr = 1; softint_clr_mask = m;
        @(negedge clk);
        softint_clr = 0; softint_clr_mask = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(5);
        rst = 0;
        @(negedge clk);
        // R1
        check("R1 softint after reset", {47'd0, softint}, 64'd0);
        check("R1 rd_valid after reset", {63'd0, rd_valid}, 64'd0);
        op(3'd5, 0, 1, '0);
        check("R1 cmp0 reset value", rd_data, TOP);
        op(3'd5, 1, 1, '0);
        check("R1 cmp1 reset value", rd_data, TOP);
        op(3'd1, 0, 1, '0);
        check("R1 R5 count flag set", {63'd0, rd_data[63]}, 64'd1);
        // R6 blocked
        op(3'd1, 0, 0, '0);
        check("R6 blocked read data", rd_data, 64'd0);
        check("R6 blocked read fault", {63'd0, priv_fault}, 64'd1);
        // R3 write then read
        op(3'd2, 0, 1, 64'h0123_4567_89AB_CDEF);
        op(3'd1, 0, 0, '0);
        check("R3 R6 written count unpriv", rd_data, 64'h0123_4567_89AB_CDEF);
        check("R6 no fault flag clear", {63'd0, priv_fault}, 64'd0);
        // R4 adjust
        op(3'd2, 0, 1, 64'd1000);
        op(3'd3, 0, 1, 64'd50);
        op(3'd1, 0, 1, '0);
        check("R4 adjusted count", rd_data, 64'd1051);
        // R2 wrap, flag clear and set
        op(3'd2, 0, 1, LOW_MASK);
        idle(1);
        op(3'd1, 0, 1, '0);
        check("R2 wrap flag clear", rd_data, 64'd0);
        op(3'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
        idle(1);
        op(3'd1, 0, 1, '0);
        check("R2 wrap flag set", rd_data, TOP);
        // R13 unused op
        op(3'd6, 0, 1, 64'd77);
        check("R13 unused op no read", {63'd0, rd_valid}, 64'd0);
        // R8 channel 0 timing
        op(3'd2, 0, 1, 64'd100);
        op(3'd4, 0, 1, 64'd105);
        idle(4);
        check("R8 not yet set", {63'd0, softint[0]}, 64'd0);
        idle(1);
        check("R8 ch0 set on match", {63'd0, softint[0]}, 64'd1);
        // R11 masking
        clr(17'h10000);
        check("R11 other bit kept", {63'd0, softint[0]}, 64'd1);
        idle(3);
        check("R11 holds", {63'd0, softint[0]}, 64'd1);
        clr(17'h00001);
        check("R11 cleared", {63'd0, softint[0]}, 64'd0);
        // R12 clear on match cycle
        op(3'd2, 0, 1, 64'd300);
        op(3'd4, 0, 1, 64'd305);
        idle(4);
        clr(17'h00001);
        check("R12 match beats clear", {63'd0, softint[0]}, 64'd1);
        clr(17'h00001);
        // R9 disabled compare
        op(3'd2, 0, 1, 64'd500);
        op(3'd4, 0, 1, TOP | 64'd505);
        idle(20);
        check("R9 disabled no fire", {63'd0, softint[0]}, 64'd0);
        op(3'd5, 0, 0, '0);
        check("R7 readback with flag", rd_data, TOP | 64'd505);
        // R10 past value
        op(3'd2, 0, 1, 64'd1000);
        op(3'd4, 1, 1, 64'd10);
        idle(40);
        check("R10 past value no fire", {63'd0, softint[16]}, 64'd0);
        // R8 channel 1
        op(3'd2, 0, 1, 64'd2000);
        op(3'd4, 1, 1, 64'd2005);
        idle(5);
        check("R8 ch1 uses bit 16", {47'd0, softint}, 64'h10000);
        op(3'd5, 1, 1, '0);
        check("R7 ch1 readback", rd_data, 64'd2005);
        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule